// File: doc/BRIEF.md
# Host Parallel Byte Port with Ready Handshake

This block lets an external host processor exchange single bytes with a controller core over an 8-bit bidirectional pad group. The core owns an 8-bit latch (the "Q" byte) which it can load a nibble or a whole byte at a time. In normal operation a program-controlled drive enable decides whether the latch is driven onto the pads or the pads float as inputs.

When the mode pin is pulled low, three general inputs become the host's active-low read strobe, chip select and write strobe. A selected read puts the latch on the pads for the host. A selected write stores the pad value into the latch and clears a ready flag. The core raises that flag with a one-cycle request to tell the host that a new byte is waiting.

All host strobes come from another clock domain. They pass through two-flop synchronizers. The pad data passes through a matching two-stage pipe, so the byte captured at the end of a write is the one present while the strobe was still low.

Top module: `hbp_port`

## Requirements
- R1: After reset, `q_out` is 0, `rdy` is 0 and `l_oe` is 0.
- R2: `core_load` encodes the core write: 2'b00 does nothing, 2'b01 loads `core_data[3:0]` into Q[3:0], 2'b10 loads `core_data[3:0]` into Q[7:4], and 2'b11 loads all of `core_data[7:0]`. The other nibble keeps its value, and Q appears on `q_out` after the next clock edge.
- R3: Outside a host read, `l_oe` equals `drv_en` delayed by one clock. `l_dout` always carries Q.
- R4: In bus mode (`bus_mode_n`=0), with `cs_n` and `rd_n` both low, `l_oe` goes to 1 on the third clock edge after the strobes fall, whatever `drv_en` is. It returns to `drv_en` three edges after the strobe rises.
- R5: In bus mode, a selected write (`cs_n`=0, `wr_n` low then high) loads Q with the `l_din` value present before `wr_n` rose. Q changes on the third clock edge after the rise, and data changed with or after the rise is not taken.
- R6: While `cs_n` is high, `rd_n` and `wr_n` have no effect on Q, `rdy` or `l_oe`.
- R7: With `bus_mode_n`=1, all three strobes are ignored: Q, `rdy` and `l_oe` are unaffected.
- R8: A one-cycle `rdy_req` sets `rdy` on the next edge. A selected host write clears `rdy` on the same edge that loads Q.
- R9: When a host write completes in the same cycle as a core load or `rdy_req`, the host write wins: Q takes the host byte and `rdy` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode_n | input | 1 | Low selects host bus mode |
| rd_n | input | 1 | Host read strobe, active low |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| l_din | input | 8 | Value seen on the pads |
| core_load | input | 2 | Core load code (see R2) |
| core_data | input | 8 | Core load data |
| drv_en | input | 1 | Program drive enable |
| rdy_req | input | 1 | Core request to raise ready |
| l_dout | output | 8 | Pad drive value |
| l_oe | output | 1 | Pad output enable |
| q_out | output | 8 | Latch contents |
| rdy | output | 1 | Ready handshake to the host |

## Verification
A wrong synchronizer or edge-detector state shows up as a wrong Q or a misplaced `l_oe` exactly three edges after a strobe changes. The bench therefore checks both the cycle before that edge and the cycle after it. A mis-timed data pipe would load the byte placed on the pads after the write strobe rose. The bench changes `l_din` at that moment so such a fault is visible as soon as Q updates. A wrong priority between the host and the core shows up only when both act in the same cycle, so the bench lines the core load and the ready request up with the write edge.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    typedef enum logic [1:0] {
        LD_NONE = 2'b00,
        LD_LO   = 2'b01,
        LD_HI   = 2'b10,
        LD_BYTE = 2'b11
    } core_ld_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter logic RST_V = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {(STAGES*W){RST_V}};
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode_n,
    input  logic rd_s,
    input  logic cs_s,
    input  logic wr_s,
    output logic host_rd,
    output logic host_wr_low,
    output logic wr_rise
);
    typedef struct packed {
        logic wr_prev;
    } dec_t;

    dec_t st_d, st_q;
    logic selected;

    always_comb begin
        selected    = !bus_mode_n && !cs_s;
        host_rd     = selected && !rd_s;
        host_wr_low = selected && !wr_s;
        wr_rise     = selected && wr_s && !st_q.wr_prev;
        st_d        = st_q;
        st_d.wr_prev = wr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wr_prev: 1'b1};
        else        st_q <= st_d;
    end

    // R6: no host action while chip select is high
    a_r6_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> (!host_rd && !wr_rise && !host_wr_low));
    // R7: no host action outside bus mode
    a_r7_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode_n |-> (!host_rd && !wr_rise));
    // R5: a rise is reported only after the strobe was low
    a_r5_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |-> !$past(wr_s));
endmodule

// File: rtl/hbp_latch.sv
module hbp_latch
    import hbp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    core_load,
    input  logic [DW-1:0] core_data,
    input  logic          rdy_req,
    input  logic          drv_en,
    input  logic          host_rd,
    input  logic          host_wr_low,
    input  logic          wr_rise,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] q,
    output logic          oe,
    output logic          rdy
);
    localparam int NIB = DW / 2;

    typedef struct packed {
        logic [DW-1:0] q;
        logic [DW-1:0] wdat;
        logic          oe;
        logic          rdy;
    } lat_t;

    lat_t st_d, st_q;
    core_ld_e ld;

    always_comb begin
        ld   = core_ld_e'(core_load);
        st_d = st_q;
        if (host_wr_low) st_d.wdat = bus_data;
        if (wr_rise) begin
            st_d.q = st_q.wdat;
        end else begin
            case (ld)
                LD_LO:   st_d.q[NIB-1:0]  = core_data[NIB-1:0];
                LD_HI:   st_d.q[DW-1:NIB] = core_data[NIB-1:0];
                LD_BYTE: st_d.q           = core_data;
                default: ;
            endcase
        end
        if (wr_rise)      st_d.rdy = 1'b0;
        else if (rdy_req) st_d.rdy = 1'b1;
        st_d.oe = host_rd || drv_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q   = st_q.q;
    assign oe  = st_q.oe;
    assign rdy = st_q.rdy;

    // R8: ready request sets the flag when no host write competes
    a_r8_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_req && !wr_rise) |=> rdy);
    // R8/R9: host write always clears ready
    a_r9_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> !rdy);
    // R2: latch holds when neither side writes
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_load == 2'b00 && !wr_rise) |=> $stable(q));
    // R3: drive enable alone turns the drivers on
    a_r3_drv_on: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |=> oe);
    // R4: host read turns the drivers on
    a_r4_rd_on: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> oe);
endmodule

// File: rtl/hbp_port.sv
module hbp_port #(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode_n,
    input  logic          rd_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [DW-1:0] l_din,
    input  logic [1:0]    core_load,
    input  logic [DW-1:0] core_data,
    input  logic          drv_en,
    input  logic          rdy_req,
    output logic [DW-1:0] l_dout,
    output logic          l_oe,
    output logic [DW-1:0] q_out,
    output logic          rdy
);
    logic [2:0]    strb_s;
    logic [DW-1:0] data_s;
    logic          host_rd, host_wr_low, wr_rise;

    hbp_sync #(.W(3), .STAGES(STAGES), .RST_V(1'b1)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .din({rd_n, cs_n, wr_n}), .dout(strb_s));

    hbp_sync #(.W(DW), .STAGES(STAGES), .RST_V(1'b0)) u_data_pipe (
        .clk(clk), .rst_n(rst_n), .din(l_din), .dout(data_s));

    hbp_decode u_decode (
        .clk(clk), .rst_n(rst_n), .bus_mode_n(bus_mode_n),
        .rd_s(strb_s[2]), .cs_s(strb_s[1]), .wr_s(strb_s[0]),
        .host_rd(host_rd), .host_wr_low(host_wr_low), .wr_rise(wr_rise));

    hbp_latch #(.DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .core_load(core_load), .core_data(core_data),
        .rdy_req(rdy_req), .drv_en(drv_en), .host_rd(host_rd),
        .host_wr_low(host_wr_low), .wr_rise(wr_rise), .bus_data(data_s),
        .q(q_out), .oe(l_oe), .rdy(rdy));

    assign l_dout = q_out;

    // R1: reset state seen right after reset release
    a_r1_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (q_out == '0 && !rdy && !l_oe));
endmodule

// File: tb/hbp_port_bench.sv
module hbp_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode_n = 1'b1, rd_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1;
    logic [7:0] l_din = 8'h00, core_data = 8'h00;
    logic [1:0] core_load = 2'b00;
    logic       drv_en = 1'b0, rdy_req = 1'b0;
    logic [7:0] l_dout, q_out;
    logic       l_oe, rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hbp_port u_hbp_port (
        .clk(clk), .rst_n(rst_n), .bus_mode_n(bus_mode_n), .rd_n(rd_n),
        .cs_n(cs_n), .wr_n(wr_n), .l_din(l_din), .core_load(core_load),
        .core_data(core_data), .drv_en(drv_en), .rdy_req(rdy_req),
        .l_dout(l_dout), .l_oe(l_oe), .q_out(q_out), .rdy(rdy));

    typedef struct {
        string      tag;
        logic [7:0] q;
        logic       oe;
        logic       rd;
    } item_t;

    item_t sb[$];
    event  chk_ev;

    // driver side: push one expected item
    task automatic expect_out(input string tag, input logic [7:0] q,
                              input logic oe, input logic rd);
        item_t it;
        #1;
        it.tag = tag; it.q = q; it.oe = oe; it.rd = rd;
        sb.push_back(it);
        ->chk_ev;
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (q_out !== it.q || l_dout !== it.q || l_oe !== it.oe || rdy !== it.rd) begin
                    fails++;
                    $display("FAIL %s: q=%h dout=%h oe=%b rdy=%b expected q=%h oe=%b rdy=%b",
                             it.tag, q_out, l_dout, l_oe, rdy, it.q, it.oe, it.rd);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic cs, input logic [7:0] d);
        cs_n = cs; l_din = d; wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1; l_din = ~d;
        cyc(5);
        cs_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        expect_out("R1 reset held", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc(2);
        expect_out("R1 after reset", 8'h00, 1'b0, 1'b0);

        // R2 core loads
        core_load = 2'b11; core_data = 8'hA5; cyc(1); core_load = 2'b00;
        expect_out("R2 byte load", 8'hA5, 1'b0, 1'b0);
        core_load = 2'b01; core_data = 8'hF3; cyc(1); core_load = 2'b00;
        expect_out("R2 low nibble", 8'hA3, 1'b0, 1'b0);
        core_load = 2'b10; core_data = 8'h0C; cyc(1); core_load = 2'b00;
        expect_out("R2 high nibble", 8'hC3, 1'b0, 1'b0);

        // R3 drive enable
        drv_en = 1'b1; cyc(1);
        expect_out("R3 enable on", 8'hC3, 1'b1, 1'b0);
        drv_en = 1'b0; cyc(1);
        expect_out("R3 enable off", 8'hC3, 1'b0, 1'b0);

        // R7 strobes ignored outside bus mode
        cs_n = 1'b0; rd_n = 1'b0; cyc(5);
        expect_out("R7 read ignored", 8'hC3, 1'b0, 1'b0);
        rd_n = 1'b1; cs_n = 1'b1;
        rdy_req = 1'b1; cyc(1); rdy_req = 1'b0;
        host_write(1'b0, 8'h5A);
        expect_out("R7 write ignored", 8'hC3, 1'b0, 1'b1);

        bus_mode_n = 1'b0; cyc(2);

        // R6 chip select gating
        rd_n = 1'b0; cyc(5);
        expect_out("R6 read without cs", 8'hC3, 1'b0, 1'b1);
        rd_n = 1'b1;
        host_write(1'b1, 8'h5A);
        expect_out("R6 write without cs", 8'hC3, 1'b0, 1'b1);

        // R4 host read latency
        cs_n = 1'b0; rd_n = 1'b0; cyc(2);
        expect_out("R4 before third edge", 8'hC3, 1'b0, 1'b1);
        cyc(1);
        expect_out("R4 on third edge", 8'hC3, 1'b1, 1'b1);
        rd_n = 1'b1; cs_n = 1'b1; cyc(2);
        expect_out("R4 release pending", 8'hC3, 1'b1, 1'b1);
        cyc(1);
        expect_out("R4 released", 8'hC3, 1'b0, 1'b1);

        // R5 / R8 host write captures pre-rise data and clears ready
        cs_n = 1'b0; l_din = 8'h96; wr_n = 1'b0; cyc(4);
        wr_n = 1'b1; l_din = 8'h11; cyc(2);
        expect_out("R5 before capture", 8'hC3, 1'b0, 1'b1);
        cyc(1);
        expect_out("R5 R8 captured and cleared", 8'h96, 1'b0, 1'b0);
        cs_n = 1'b1; cyc(2);

        // R8 ready set
        rdy_req = 1'b1; cyc(1); rdy_req = 1'b0;
        expect_out("R8 ready set", 8'h96, 1'b0, 1'b1);

        // R9 host write wins over core load and ready request
        cs_n = 1'b0; l_din = 8'h3C; wr_n = 1'b0; cyc(4);
        wr_n = 1'b1; l_din = 8'h00; cyc(2);
        core_load = 2'b11; core_data = 8'hEE; rdy_req = 1'b1;
        cyc(1);
        core_load = 2'b00; rdy_req = 1'b0;
        expect_out("R9 host wins", 8'h3C, 1'b0, 1'b0);
        cs_n = 1'b1; cyc(2);

        // R3 read while enable set stays driven after release
        drv_en = 1'b1; cs_n = 1'b0; rd_n = 1'b0; cyc(4);
        rd_n = 1'b1; cs_n = 1'b1; cyc(4);
        expect_out("R3 enable after read", 8'h3C, 1'b1, 1'b0);
        drv_en = 1'b0; cyc(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule